// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the enable and address of each port every clock. When both ports are enabled on the same location, it decides which port keeps access and drives an active-low busy flag toward the other. It also gates that port's write strobe, so the write is dropped rather than stalled. The port that was already enabled on that address in the previous cycle wins. If both ports arrive in the same cycle, the left port wins.

A mode input selects the role. In master mode the block arbitrates itself and drives both busy flags from registers. In slave mode it ignores its own decision, holds its busy outputs high, and takes the busy level from external inputs, which then only suppress writes on the matching port. The write qualifiers are the strobes the memory array should actually use.

Top module: `dpCollisionArbiter`

## Requirements
- R1: When the two port addresses differ, both busy outputs are high after the next rising clock edge.
- R2: When either port enable is low, both busy outputs are high after the next rising clock edge, even if the addresses are equal.
- R3: In master mode, when both ports are enabled on equal addresses and exactly one port is settled, the other port loses. A port is settled if it was enabled on the same address in the previous cycle. The loser's busy output goes low at the next rising edge, and the winner's write qualifier follows its write strobe.
- R4: The two busy outputs are never low at the same time.
- R5: In master mode a port's write qualifier is high only when its write strobe is high, the port is not losing a collision in the current cycle, and its own busy output is not low.
- R6: In slave mode a low level on a port's busy input (active low) forces that port's write qualifier low. Internal arbitration has no effect on either qualifier, and both busy outputs are high after the next rising edge.
- R7: A collision that continues on the same address keeps its winner from cycle to cycle, even though both ports are settled by then.
- R8: When a collision begins and neither port is settled, the left port wins and the right busy output goes low at the next rising edge.
- R9: A busy output returns high in the first cycle after the collision ends. During the cycle in which busy is still low, that port's write qualifier stays low.
- R10: Asserting the asynchronous active-low reset sets both busy outputs high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = arbitrate internally, 0 = follow external busy inputs |
| leftEn | input | 1 | Left port enable, active high |
| leftAddr | input | ADDR_W | Left port address |
| leftWe | input | 1 | Left port write strobe, active high |
| rightEn | input | 1 | Right port enable, active high |
| rightAddr | input | ADDR_W | Right port address |
| rightWe | input | 1 | Right port write strobe, active high |
| busyInLeftN | input | 1 | External busy for the left port in slave mode, active low |
| busyInRightN | input | 1 | External busy for the right port in slave mode, active low |
| busyOutLeftN | output | 1 | Registered busy toward the left port, active low |
| busyOutRightN | output | 1 | Registered busy toward the right port, active low |
| leftWeQual | output | 1 | Left write strobe after inhibit |
| rightWeQual | output | 1 | Right write strobe after inhibit |

## Verification
The stimulus makes each port in turn the settled one, so a design that ignored arrival order would always flag the right port. It also holds a collision for two cycles, where both ports are settled; a design without a stored winner would fall back to the tie rule and flip the loser. The cycle after a collision ends is checked with the write strobe still high, which catches a qualifier that looks only at the current match and lets a write slip past a busy flag that is still low. Slave-mode vectors put a collision on the pins together with external busy levels that disagree with internal arbitration, which exposes a design that leaks its own decision into the qualifiers or the outputs.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  // Per-cycle decision handed from control to datapath
  typedef struct packed {
    logic collide;
    logic loseLeft;
    logic loseRight;
  } arbStrobeS;

  localparam int PORTS = 2;
  localparam int LEFT_IDX = 0;
  localparam int RIGHT_IDX = 1;

endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  output arbStrobeS         strobe
);

  logic              prevLeftEn, prevRightEn, prevCollide;
  logic [ADDR_W-1:0] prevLeftAddr, prevRightAddr;
  ownerE             ownerQ, ownerD;

  logic addrEq, collide, leftSettled, rightSettled, continuing;

  always_comb begin
    addrEq       = (leftAddr == rightAddr);
    collide      = leftEn && rightEn && addrEq;
    leftSettled  = prevLeftEn && (prevLeftAddr == leftAddr);
    rightSettled = prevRightEn && (prevRightAddr == rightAddr);
    continuing   = prevCollide && (prevLeftAddr == leftAddr)
                   && (prevRightAddr == rightAddr);
  end

  // Winner selection: hold an ongoing winner, else first-settled, else left
  always_comb begin
    ownerD = OWN_NONE;
    if (collide) begin
      if (continuing && ownerQ != OWN_NONE) begin
        ownerD = ownerQ;
      end else if (rightSettled && !leftSettled) begin
        ownerD = OWN_RIGHT;
      end else begin
        ownerD = OWN_LEFT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLeftEn    <= 1'b0;
      prevRightEn   <= 1'b0;
      prevCollide   <= 1'b0;
      prevLeftAddr  <= '0;
      prevRightAddr <= '0;
      ownerQ        <= OWN_NONE;
    end else begin
      prevLeftEn    <= leftEn;
      prevRightEn   <= rightEn;
      prevCollide   <= collide;
      prevLeftAddr  <= leftAddr;
      prevRightAddr <= rightAddr;
      ownerQ        <= ownerD;
    end
  end

  always_comb begin
    strobe.collide   = collide;
    strobe.loseLeft  = (ownerD == OWN_RIGHT);
    strobe.loseRight = (ownerD == OWN_LEFT);
  end

endmodule

// File: rtl/arbPath.sv
module arbPath
  import arbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  arbStrobeS strobe,
  input  logic      leftWe,
  input  logic      rightWe,
  input  logic      busyInLeftN,
  input  logic      busyInRightN,
  output logic      busyOutLeftN,
  output logic      busyOutRightN,
  output logic      leftWeQual,
  output logic      rightWeQual
);

  logic [PORTS-1:0] loseVec, weVec, busyInVec, busyRegN, qualVec;

  always_comb begin
    loseVec[LEFT_IDX]    = strobe.loseLeft;
    loseVec[RIGHT_IDX]   = strobe.loseRight;
    weVec[LEFT_IDX]      = leftWe;
    weVec[RIGHT_IDX]     = rightWe;
    busyInVec[LEFT_IDX]  = busyInLeftN;
    busyInVec[RIGHT_IDX] = busyInRightN;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic inhibit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) busyRegN[p] <= 1'b1;
      else       busyRegN[p] <= !(masterMode && loseVec[p]);
    end

    always_comb begin
      if (masterMode) inhibit = loseVec[p] || !busyRegN[p];
      else            inhibit = !busyInVec[p];
      qualVec[p] = weVec[p] && !inhibit;
    end
  end

  assign busyOutLeftN  = busyRegN[LEFT_IDX];
  assign busyOutRightN = busyRegN[RIGHT_IDX];
  assign leftWeQual    = qualVec[LEFT_IDX];
  assign rightWeQual   = qualVec[RIGHT_IDX];

endmodule

// File: rtl/dpCollisionArbiter.sv
module dpCollisionArbiter
  import arbPkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              busyInLeftN,
  input  logic              busyInRightN,
  output logic              busyOutLeftN,
  output logic              busyOutRightN,
  output logic              leftWeQual,
  output logic              rightWeQual
);

  arbStrobeS strobe;

  arbCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .leftEn(leftEn), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightAddr(rightAddr),
    .strobe(strobe)
  );

  arbPath u_path (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .strobe(strobe),
    .leftWe(leftWe), .rightWe(rightWe),
    .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
    .busyOutLeftN(busyOutLeftN), .busyOutRightN(busyOutRightN),
    .leftWeQual(leftWeQual), .rightWeQual(rightWeQual)
  );

endmodule

// File: rtl/arbChecker.sv
module arbChecker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              leftEn,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftWe,
  input logic              rightEn,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightWe,
  input logic              busyInLeftN,
  input logic              busyInRightN,
  input logic              busyOutLeftN,
  input logic              busyOutRightN,
  input logic              leftWeQual,
  input logic              rightWeQual
);

  logic hit;
  assign hit = leftEn && rightEn && (leftAddr == rightAddr);

  p_addr_differ_r1: assert property (@(posedge clk) disable iff (!rstN)
    (leftAddr != rightAddr) |=> (busyOutLeftN && busyOutRightN));

  p_enable_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!leftEn || !rightEn) |=> (busyOutLeftN && busyOutRightN));

  p_first_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && hit && $past(leftEn) && ($past(leftAddr) == leftAddr)
     && !($past(rightEn) && ($past(rightAddr) == rightAddr)))
    |=> !busyOutRightN);

  p_never_both_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busyOutLeftN || busyOutRightN));

  p_master_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyOutLeftN) |-> !leftWeQual);

  p_master_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyOutRightN) |-> !rightWeQual);

  p_qual_needs_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((leftWeQual |-> leftWe) and (rightWeQual |-> rightWe)));

  p_slave_inhibit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && (!busyInLeftN || !busyInRightN))
    |-> !((!busyInLeftN && leftWeQual) || (!busyInRightN && rightWeQual)));

  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (busyOutLeftN && busyOutRightN));

  p_tie_left_r8: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && hit && !$past(leftEn) && !$past(rightEn))
    |=> !busyOutRightN);

endmodule

bind dpCollisionArbiter arbChecker #(.ADDR_W(ADDR_W)) u_arbChecker (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .leftEn(leftEn), .leftAddr(leftAddr), .leftWe(leftWe),
  .rightEn(rightEn), .rightAddr(rightAddr), .rightWe(rightWe),
  .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
  .busyOutLeftN(busyOutLeftN), .busyOutRightN(busyOutRightN),
  .leftWeQual(leftWeQual), .rightWeQual(rightWeQual)
);

// File: tb/test_dpCollisionArbiter.sv
module test_dpCollisionArbiter;

  localparam int ADDR_W = 14;
  localparam int NVEC = 16;

  typedef struct packed {
    logic              mm;
    logic              lEn;
    logic [ADDR_W-1:0] lAddr;
    logic              lWe;
    logic              rEn;
    logic [ADDR_W-1:0] rAddr;
    logic              rWe;
    logic              bInL;
    logic              bInR;
    logic              eLQ;
    logic              eRQ;
    logic              eBL;
    logic              eBR;
  } vecT;

  // mm lEn lAddr lWe rEn rAddr rWe bInL bInR | eLQ eRQ (same cycle) eBL eBR (after edge)
  localparam vecT VECS [NVEC] = '{
    '{1,1,5,1, 1,9,1, 1,1, 1,1, 1,1},
    '{1,1,5,1, 1,5,1, 1,1, 1,0, 1,0},
    '{1,1,5,1, 1,5,1, 1,1, 1,0, 1,0},
    '{1,1,5,1, 1,9,1, 1,1, 1,0, 1,1},
    '{1,1,9,1, 1,9,1, 1,1, 0,1, 0,1},
    '{1,1,9,1, 1,9,1, 1,1, 0,1, 0,1},
    '{1,0,9,1, 1,9,1, 1,1, 0,1, 1,1},
    '{1,0,0,1, 0,0,1, 1,1, 1,1, 1,1},
    '{1,1,5,1, 1,5,1, 1,1, 1,0, 1,0},
    '{1,0,5,1, 0,5,1, 1,1, 1,0, 1,1},
    '{1,1,5,1, 0,5,1, 1,1, 1,1, 1,1},
    '{0,1,5,1, 1,5,1, 0,1, 0,1, 1,1},
    '{0,1,5,1, 1,5,1, 1,0, 1,0, 1,1},
    '{1,1,7,1, 1,7,1, 1,1, 1,0, 1,0},
    '{0,1,7,1, 1,7,1, 1,1, 1,1, 1,1},
    '{1,1,7,0, 1,7,1, 1,1, 0,0, 1,0}
  };

  localparam string TAGS [NVEC] = '{
    "R1", "R3", "R7", "R9", "R3", "R7", "R2", "R2",
    "R8", "R9", "R2", "R6", "R6", "R8", "R6", "R5"
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              masterMode = 1'b1;
  logic              leftEn = 1'b0, rightEn = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic              leftWe = 1'b0, rightWe = 1'b0;
  logic              busyInLeftN = 1'b1, busyInRightN = 1'b1;
  logic              busyOutLeftN, busyOutRightN, leftWeQual, rightWeQual;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpCollisionArbiter #(.ADDR_W(ADDR_W)) i_dpCollisionArbiter (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWe(leftWe),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWe(rightWe),
    .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
    .busyOutLeftN(busyOutLeftN), .busyOutRightN(busyOutRightN),
    .leftWeQual(leftWeQual), .rightWeQual(rightWeQual)
  );

  task automatic check2(input string tag, input string what,
                        input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vecT v);
    masterMode   = v.mm;
    leftEn       = v.lEn;
    leftAddr     = v.lAddr;
    leftWe       = v.lWe;
    rightEn      = v.rEn;
    rightAddr    = v.rAddr;
    rightWe      = v.rWe;
    busyInLeftN  = v.bInL;
    busyInRightN = v.bInR;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state (R10)
    repeat (3) @(posedge clk);
    #1 check2("R10", "busy during reset", {busyOutLeftN, busyOutRightN}, 2'b11);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1 check2(TAGS[i], $sformatf("qual v%0d", i),
                {leftWeQual, rightWeQual}, {VECS[i].eLQ, VECS[i].eRQ});
      @(posedge clk);
      #1 check2(TAGS[i], $sformatf("busy v%0d", i),
                {busyOutLeftN, busyOutRightN}, {VECS[i].eBL, VECS[i].eBR});
      check2("R4", $sformatf("exclusive v%0d", i),
             {busyOutLeftN | busyOutRightN, 1'b1}, 2'b11);
    end

    // Directed: idle, then a fresh collision, then asynchronous reset (R10)
    @(negedge clk);
    drive('{1,0,0,1, 0,0,1, 1,1, 0,0, 0,0});
    @(negedge clk);
    drive('{1,1,3,1, 1,3,1, 1,1, 0,0, 0,0});
    @(posedge clk);
    #1 check2("R8", "busy before reset", {busyOutLeftN, busyOutRightN}, 2'b10);
    @(negedge clk);
    rstN = 1'b0;
    #1 check2("R10", "busy at async reset", {busyOutLeftN, busyOutRightN}, 2'b11);
    @(negedge clk);
    rstN = 1'b1;
    drive('{1,0,0,0, 0,0,0, 1,1, 0,0, 0,0});
    @(posedge clk);
    #1 check2("R10", "busy after release", {busyOutLeftN, busyOutRightN}, 2'b11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule